// File: doc/BRIEF.md
# Bypassed Multiport Floating-Point Register File

This block holds the floating-point operand registers of a processor core: thirty-two 64-bit entries, four read ports and two write ports, all usable in every cycle. Read ports 0 to 2 and write port 0 belong to the three-operand fused multiply-add path. Read port 3 and write port 1 belong to the memory path, which covers loads, stores and conditional moves. A 64-bit load or store can therefore run in every cycle without taking operand bandwidth from the arithmetic path.

Every read port forwards a write that is presented in the same cycle, so a consumer that issues right behind its producer needs no extra cycle. When both write ports target one entry, the arithmetic result wins in the array and in the forwarding path.

A small side register pair goes with the file. One register is a read-only configuration/revision word that reset loads with a fixed constant. The other is a writable 32-bit control/status word whose low two bits select the rounding mode.

Top module: `fpr_bank`

## Requirements
- R1: After reset every entry reads 0 on every read port, the control word reads 0 (round to nearest), and the configuration word reads the parameter `REV_ID`.
- R2: A write on either write port is stored at the clock edge and reads back on all four read ports from the next cycle onward.
- R3: Each read port whose address matches an enabled write in the same cycle returns that write's data in that same cycle.
- R4: When both write ports are enabled for the same address, write port 0 data is forwarded in that cycle and is the value stored.
- R5: Two enabled writes to different addresses in one cycle are both stored.
- R6: A write port with its enable low changes no entry and forwards nothing, whatever its address and data.
- R7: Bits [1:0] of the control word drive `round_mode_o` with the encoding 0 = nearest, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity. A control write (`csr_sel_i`=1) takes effect in the next cycle.
- R8: A write with `csr_sel_i`=0 (configuration word) is ignored: the configuration word keeps reading `REV_ID` and the control word does not change.
- R9: The control word stores all 32 written bits and returns them on `csr_rdata_o` while `csr_sel_i`=1.
- R10: Write port 1 accepts a new write in every cycle; a run of back-to-back writes to consecutive entries is stored in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_addr_i | input | 4x5 | Read addresses; [0..2] multiply-add operands, [3] memory path |
| rd_data_o | output | 4x64 | Forwarded read data, one word per read port |
| wr_en_i | input | 2 | Write enables; [0] arithmetic result, [1] memory path |
| wr_addr_i | input | 2x5 | Write addresses |
| wr_data_i | input | 2x64 | Write data |
| csr_sel_i | input | 1 | Side register select: 0 configuration, 1 control/status |
| csr_we_i | input | 1 | Side register write strobe |
| csr_wdata_i | input | 32 | Side register write data |
| csr_rdata_o | output | 32 | Selected side register |
| round_mode_o | output | 2 | Current rounding mode |

## Verification
The arithmetic write-back and a memory-path write can land in the same cycle. They may target two different entries, or both may target the entry that a read port is addressing in that cycle. The bench provokes both cases by driving both write ports in one cycle. The forwarded value is judged during that cycle, before the clock edge, and the stored value is judged in the cycle after it. In both cases the expected word is the arithmetic one when the addresses collide, and each port's own data when they differ.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  localparam int RD_PORTS = 4;
  localparam int WR_PORTS = 2;
  localparam int WP_ARITH = 0;
  localparam int WP_MEM   = 1;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'd0,
    RM_ZERO    = 2'd1,
    RM_POS_INF = 2'd2,
    RM_NEG_INF = 2'd3
  } round_mode_e;

  typedef enum logic {
    CSR_CFG  = 1'b0,
    CSR_CTRL = 1'b1
  } csr_sel_e;
endpackage

// File: rtl/fpr_storage.sv
module fpr_storage #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 64,
  parameter int NUM_RD   = 4,
  parameter int NUM_WR   = 2,
  localparam int AW      = $clog2(NUM_REGS)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_WR-1:0]              wr_en_i,
  input  logic [NUM_WR-1:0][AW-1:0]      wr_addr_i,
  input  logic [NUM_WR-1:0][DATA_W-1:0]  wr_data_i,
  input  logic [NUM_RD-1:0][AW-1:0]      rd_addr_i,
  output logic [NUM_RD-1:0][DATA_W-1:0]  rd_data_o
);
  logic [NUM_REGS-1:0][DATA_W-1:0] mem_q;

  // highest port index applied first, so port 0 lands last and wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else begin
      for (int w = NUM_WR - 1; w >= 0; w--) begin
        if (wr_en_i[w]) mem_q[wr_addr_i[w]] <= wr_data_i[w];
      end
    end
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    assign rd_data_o[r] = mem_q[rd_addr_i[r]];
  end
endmodule

// File: rtl/fpr_bypass.sv
module fpr_bypass #(
  parameter int AW     = 5,
  parameter int DATA_W = 64,
  parameter int NUM_WR = 2
) (
  input  logic [AW-1:0]                 rd_addr_i,
  input  logic [DATA_W-1:0]             stored_i,
  input  logic [NUM_WR-1:0]             wr_en_i,
  input  logic [NUM_WR-1:0][AW-1:0]     wr_addr_i,
  input  logic [NUM_WR-1:0][DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0]             rd_data_o
);
  always_comb begin
    rd_data_o = stored_i;
    for (int w = NUM_WR - 1; w >= 0; w--) begin
      if (wr_en_i[w] && (wr_addr_i[w] == rd_addr_i)) rd_data_o = wr_data_i[w];
    end
  end
endmodule

// File: rtl/fpr_ctrl_regs.sv
module fpr_ctrl_regs
  import fpr_pkg::*;
#(
  parameter int          CSR_W  = 32,
  parameter logic [31:0] REV_ID = 32'h0000_0A31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             we_i,
  input  logic [CSR_W-1:0] wdata_i,
  output logic [CSR_W-1:0] rdata_o,
  output round_mode_e      round_mode_o
);
  logic [CSR_W-1:0] cfg_q;
  logic [CSR_W-1:0] ctrl_q;

  // revision word: loaded at reset, no write path
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= CSR_W'(REV_ID);
    else         cfg_q <= cfg_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               ctrl_q <= '0;
    else if (we_i && csr_sel_e'(sel_i) == CSR_CTRL) ctrl_q <= wdata_i;
  end

  assign rdata_o      = (csr_sel_e'(sel_i) == CSR_CTRL) ? ctrl_q : cfg_q;
  assign round_mode_o = round_mode_e'(ctrl_q[1:0]);
endmodule

// File: rtl/fpr_bank.sv
module fpr_bank
  import fpr_pkg::*;
#(
  parameter int          NUM_REGS = 32,
  parameter int          DATA_W   = 64,
  parameter int          CSR_W    = 32,
  parameter logic [31:0] REV_ID   = 32'h0000_0A31,
  localparam int         AW       = $clog2(NUM_REGS)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [RD_PORTS-1:0][AW-1:0]      rd_addr_i,
  output logic [RD_PORTS-1:0][DATA_W-1:0]  rd_data_o,
  input  logic [WR_PORTS-1:0]              wr_en_i,
  input  logic [WR_PORTS-1:0][AW-1:0]      wr_addr_i,
  input  logic [WR_PORTS-1:0][DATA_W-1:0]  wr_data_i,
  input  logic                             csr_sel_i,
  input  logic                             csr_we_i,
  input  logic [CSR_W-1:0]                 csr_wdata_i,
  output logic [CSR_W-1:0]                 csr_rdata_o,
  output logic [1:0]                       round_mode_o
);
  logic [RD_PORTS-1:0][DATA_W-1:0] stored;
  round_mode_e rm;

  fpr_storage #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .NUM_RD(RD_PORTS), .NUM_WR(WR_PORTS)
  ) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i),
    .rd_data_o(stored)
  );

  for (genvar r = 0; r < RD_PORTS; r++) begin : g_fwd
    fpr_bypass #(.AW(AW), .DATA_W(DATA_W), .NUM_WR(WR_PORTS)) u_fwd (
      .rd_addr_i(rd_addr_i[r]),
      .stored_i (stored[r]),
      .wr_en_i  (wr_en_i),
      .wr_addr_i(wr_addr_i),
      .wr_data_i(wr_data_i),
      .rd_data_o(rd_data_o[r])
    );
  end

  fpr_ctrl_regs #(.CSR_W(CSR_W), .REV_ID(REV_ID)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_i       (csr_sel_i),
    .we_i        (csr_we_i),
    .wdata_i     (csr_wdata_i),
    .rdata_o     (csr_rdata_o),
    .round_mode_o(rm)
  );

  assign round_mode_o = rm;
endmodule

// File: rtl/fpr_bank_chk.sv
module fpr_bank_chk
  import fpr_pkg::*;
#(
  parameter int          NUM_REGS = 32,
  parameter int          DATA_W   = 64,
  parameter int          CSR_W    = 32,
  parameter logic [31:0] REV_ID   = 32'h0000_0A31,
  localparam int         AW       = $clog2(NUM_REGS)
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic [RD_PORTS-1:0][AW-1:0]      rd_addr_i,
  input logic [RD_PORTS-1:0][DATA_W-1:0]  rd_data_o,
  input logic [WR_PORTS-1:0]              wr_en_i,
  input logic [WR_PORTS-1:0][AW-1:0]      wr_addr_i,
  input logic [WR_PORTS-1:0][DATA_W-1:0]  wr_data_i,
  input logic                             csr_sel_i,
  input logic                             csr_we_i,
  input logic [CSR_W-1:0]                 csr_wdata_i,
  input logic [CSR_W-1:0]                 csr_rdata_o,
  input logic [1:0]                       round_mode_o
);
  for (genvar r = 0; r < RD_PORTS; r++) begin : g_rp
    AST_FWD_ARITH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i[0] && wr_addr_i[0] == rd_addr_i[r]) |-> rd_data_o[r] == wr_data_i[0]); // R4
    AST_FWD_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i[1] && wr_addr_i[1] == rd_addr_i[r] &&
       !(wr_en_i[0] && wr_addr_i[0] == rd_addr_i[r])) |-> rd_data_o[r] == wr_data_i[1]); // R3
  end

  AST_MEM_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i[1] && !(wr_en_i[0] && wr_addr_i[0] == wr_addr_i[1])) ##1
    (wr_en_i == '0 && rd_addr_i[3] == $past(wr_addr_i[1]))
    |-> rd_data_o[3] == $past(wr_data_i[1])); // R2

  AST_CFG_CONST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_sel_i == CSR_CFG) |-> csr_rdata_o == CSR_W'(REV_ID)); // R8

  AST_CFG_WRITE_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && csr_sel_i == CSR_CFG) |=> $stable(round_mode_o)); // R8

  AST_RM_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && csr_sel_i == CSR_CTRL) |=> round_mode_o == $past(csr_wdata_i[1:0])); // R7

  AST_RM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(csr_we_i && csr_sel_i == CSR_CTRL) |=> $stable(round_mode_o)); // R7
endmodule

bind fpr_bank fpr_bank_chk #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .CSR_W(CSR_W), .REV_ID(REV_ID)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_addr_i   (rd_addr_i),
  .rd_data_o   (rd_data_o),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .wr_data_i   (wr_data_i),
  .csr_sel_i   (csr_sel_i),
  .csr_we_i    (csr_we_i),
  .csr_wdata_i (csr_wdata_i),
  .csr_rdata_o (csr_rdata_o),
  .round_mode_o(round_mode_o)
);

// File: tb/fpr_bank_tb_top.sv
module fpr_bank_tb_top;
  localparam int          NR  = 32;
  localparam int          DW  = 64;
  localparam int          AW  = 5;
  localparam int          CW  = 32;
  localparam logic [31:0] REV = 32'h0000_0A31;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [3:0][AW-1:0]   rd_addr = '0;
  logic [3:0][DW-1:0]   rd_data;
  logic [1:0]           wr_en = '0;
  logic [1:0][AW-1:0]   wr_addr = '0;
  logic [1:0][DW-1:0]   wr_data = '0;
  logic                 csr_sel = 1'b0;
  logic                 csr_we = 1'b0;
  logic [CW-1:0]        csr_wdata = '0;
  logic [CW-1:0]        csr_rdata;
  logic [1:0]           rm;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fpr_bank #(.NUM_REGS(NR), .DATA_W(DW), .CSR_W(CW), .REV_ID(REV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .csr_sel_i(csr_sel), .csr_we_i(csr_we), .csr_wdata_i(csr_wdata),
    .csr_rdata_o(csr_rdata), .round_mode_o(rm)
  );

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // inputs change at negedge, sampled 1 ns later
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    wr_en  = '0;
    csr_we = 1'b0;
    #1;
  endtask

  task automatic read_all(logic [AW-1:0] a, logic [DW-1:0] exp, string tag);
    for (int p = 0; p < 4; p++) rd_addr[p] = a;
    #1;
    for (int p = 0; p < 4; p++) check(tag, rd_data[p], exp);
  endtask

  task automatic t_reset();
    read_all(5'd0, '0, "R1 entry0");
    read_all(5'd31, '0, "R1 entry31");
    csr_sel = 1'b0; #1;
    check("R1 cfg", DW'(csr_rdata), DW'(REV));
    csr_sel = 1'b1; #1;
    check("R1 ctrl", DW'(csr_rdata), '0);
    check("R1 rm", DW'(rm), '0);
  endtask

  task automatic t_write_read();
    wr_en = 2'b11;
    wr_addr[0] = 5'd3;  wr_data[0] = 64'hA5A5_0000_1111_0003;
    wr_addr[1] = 5'd7;  wr_data[1] = 64'h5A5A_FFFF_2222_0007;
    step();
    read_all(5'd3, 64'hA5A5_0000_1111_0003, "R2 r3");
    read_all(5'd7, 64'h5A5A_FFFF_2222_0007, "R5 r7");
  endtask

  task automatic t_bypass();
    rd_addr = {5'd10, 5'd11, 5'd10, 5'd11};
    wr_en = 2'b11;
    wr_addr[0] = 5'd11; wr_data[0] = 64'h0BAD_CAFE_0000_0011;
    wr_addr[1] = 5'd10; wr_data[1] = 64'hFEED_0000_BEEF_0010;
    #1;
    check("R3 p0", rd_data[0], 64'h0BAD_CAFE_0000_0011);
    check("R3 p1", rd_data[1], 64'hFEED_0000_BEEF_0010);
    check("R3 p2", rd_data[2], 64'h0BAD_CAFE_0000_0011);
    check("R3 p3", rd_data[3], 64'hFEED_0000_BEEF_0010);
    step();
    read_all(5'd10, 64'hFEED_0000_BEEF_0010, "R5 r10");
  endtask

  task automatic t_collide();
    for (int p = 0; p < 4; p++) rd_addr[p] = 5'd12;
    wr_en = 2'b11;
    wr_addr[0] = 5'd12; wr_data[0] = 64'h1111_2222_3333_4444;
    wr_addr[1] = 5'd12; wr_data[1] = 64'h9999_8888_7777_6666;
    #1;
    for (int p = 0; p < 4; p++) check("R4 fwd", rd_data[p], 64'h1111_2222_3333_4444);
    step();
    read_all(5'd12, 64'h1111_2222_3333_4444, "R4 stored");
  endtask

  task automatic t_no_en();
    for (int p = 0; p < 4; p++) rd_addr[p] = 5'd3;
    wr_en = 2'b00;
    wr_addr = {5'd3, 5'd3};
    wr_data = {64'hDEAD_DEAD_DEAD_DEAD, 64'hDEAD_DEAD_DEAD_DEAD};
    #1;
    check("R6 nofwd", rd_data[0], 64'hA5A5_0000_1111_0003);
    step();
    read_all(5'd3, 64'hA5A5_0000_1111_0003, "R6 nostore");
  endtask

  task automatic t_round();
    csr_sel = 1'b1;
    for (int m = 0; m < 4; m++) begin
      csr_we = 1'b1;
      csr_wdata = 32'h00C0_FF00 | 32'(m);
      step();
      check("R7 rm", DW'(rm), DW'(m));
      check("R9 word", DW'(csr_rdata), DW'(32'h00C0_FF00 | 32'(m)));
    end
  endtask

  task automatic t_cfg_ro();
    csr_sel = 1'b0;
    csr_we = 1'b1;
    csr_wdata = 32'hFFFF_FFFC;
    step();
    check("R8 cfg", DW'(csr_rdata), DW'(REV));
    check("R8 rm", DW'(rm), 64'd3);
    csr_sel = 1'b1; #1;
    check("R8 ctrl", DW'(csr_rdata), DW'(32'h00C0_FF03));
  endtask

  task automatic t_stream();
    for (int i = 0; i < 8; i++) begin
      wr_en = 2'b10;
      wr_addr[1] = AW'(16 + i);
      wr_data[1] = {32'hC0DE_0000, 32'(i * 7 + 1)};
      @(posedge clk);
      @(negedge clk);
    end
    wr_en = '0; #1;
    for (int i = 0; i < 8; i++) read_all(AW'(16 + i), {32'hC0DE_0000, 32'(i * 7 + 1)}, "R10 burst");
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_write_read();
    t_bypass();
    t_collide();
    t_no_en();
    t_round();
    t_cfg_ro();
    t_stream();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule